// File: doc/BRIEF.md
# Protection-Based Set Replacement and Bypass Unit

This unit decides, for one set of a set-associative cache, which way a miss should overwrite, or whether the miss should skip the cache altogether. Every way carries a small down-counter of remaining protection. A line whose counter is non-zero cannot be evicted. The counter is loaded when the line is filled or hit, and it ages by one on each later access to the set that targets another way.

The amount loaded comes from a small table with one protection-length entry per thread. Software, or a separate tuning engine, can rewrite any entry at run time through a write port. Lowering one thread's entry shortens how long that thread's lines stay shielded. A miss that finds every way still protected raises a bypass flag, and nothing is installed. That miss still ages the set, so protection always runs out in the end.

The tag and data arrays sit outside this unit. The logic that chooses a good protection length also sits outside it.

Top module: `pd_repl_unit`

## Requirements
- R1: After reset, `bypass_o`, `fill_ok_o` and `victim_way_o` are 0, every way is invalid, and every thread's table entry holds `DEF_PD`.
- R2: On a valid hit, the counter of the hit way is loaded with the requesting thread's entry. Every other way's counter drops by one and stops at 0.
- R3: On a valid miss where an unprotected way exists, that way becomes valid with its counter loaded from the thread's entry, and all other counters age by one. In the next cycle `fill_ok_o`=1 and `victim_way_o` gives the chosen way.
- R4: Invalid ways are chosen before any valid way with a zero counter. Among invalid ways, the lowest index wins.
- R5: When no way is invalid, the lowest-indexed valid way whose counter is 0 is chosen.
- R6: A miss with every way valid and non-zero installs nothing. In the next cycle `bypass_o`=1, `fill_ok_o`=0 and `victim_way_o`=0.
- R7: A bypassed miss ages every counter by one, stopping at 0.
- R8: A write with `pd_we_i`=1 stores `pd_data_i` into entry `pd_idx_i`. Accesses from the following cycle on load the new value. Lines loaded earlier keep their counts.
- R9: The protection loaded on a fill or hit is the entry of the accessing thread `acc_tid_i`. Other threads' entries are not used.
- R10: In a cycle following a hit or an idle cycle, `bypass_o`=0, `fill_ok_o`=0 and `victim_way_o`=0. `bypass_o` and `fill_ok_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access to the set is presented |
| acc_hit_i | input | 1 | 1 = hit, 0 = miss |
| acc_way_i | input | $clog2(WAYS) | Way that hit (used on a hit only) |
| acc_tid_i | input | $clog2(THREADS) | Thread issuing the access |
| pd_we_i | input | 1 | Protection table write enable |
| pd_idx_i | input | $clog2(THREADS) | Table entry to write |
| pd_data_i | input | CNT_W | Protection length to store |
| victim_way_o | output | $clog2(WAYS) | Way filled by the previous miss |
| bypass_o | output | 1 | Previous miss was bypassed |
| fill_ok_o | output | 1 | Previous miss was installed |

## Verification
The bench builds the unit with 4 ways, 4 threads, 4-bit counters and a default length of 3. With these values, counter saturation, a set that is fully protected, and a set that is fully unprotected are each reached within a few dozen accesses. Directed sequences set up invalid-first selection, lowest-index ties, a run of bypasses that ends in a fill, and per-thread and rewritten lengths. A long pseudo-random mix of hits, misses, threads and table writes is then checked access by access against an arithmetic model of the counters.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_FILL = 2'd1,
    OUT_BYP  = 2'd2
  } miss_out_e;
endpackage

// File: rtl/pd_table.sv
module pd_table #(
  parameter int THREADS = 4,
  parameter int CNT_W   = 8,
  parameter int DEF_PD  = 16,
  localparam int TID_W  = $clog2(THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TID_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [TID_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_pd_o
);
  logic [THREADS-1:0][CNT_W-1:0] pd_q;

  for (genvar t = 0; t < THREADS; t++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  pd_q[t] <= CNT_W'(DEF_PD);
      else if (we_i && wr_idx_i == TID_W'(t))       pd_q[t] <= wr_data_i;
    end
  end

  assign rd_pd_o = pd_q[rd_idx_i];

  // R8
  table_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> pd_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/way_ctr.sv
module way_ctr #(
  parameter int WAYS  = 8,
  parameter int CNT_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         acc_i,
  input  logic [WAYS-1:0]              ld_i,
  input  logic [WAYS-1:0]              set_vld_i,
  input  logic [CNT_W-1:0]             ld_val_i,
  output logic [WAYS-1:0][CNT_W-1:0]   cnt_o,
  output logic [WAYS-1:0]              vld_o
);
  logic [WAYS-1:0][CNT_W-1:0] cnt_q;
  logic [WAYS-1:0]            vld_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[w] <= '0;
        vld_q[w] <= 1'b0;
      end else if (acc_i) begin
        if (ld_i[w])              cnt_q[w] <= ld_val_i;
        else if (cnt_q[w] != '0)  cnt_q[w] <= cnt_q[w] - 1'b1;
        if (set_vld_i[w])         vld_q[w] <= 1'b1;
      end
    end

    // R2 R7: untouched ways age by exactly one
    age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_i && !ld_i[w] && cnt_q[w] != '0) |=> cnt_q[w] == $past(cnt_q[w]) - 1'b1);
    // R2: saturation at zero
    sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_i && !ld_i[w] && cnt_q[w] == '0) |=> cnt_q[w] == '0);
  end

  assign cnt_o = cnt_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS   = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  prot_i,
  output logic             found_o,
  output logic [WAY_W-1:0] way_o
);
  logic             inv_any, free_any;
  logic [WAY_W-1:0] inv_way, free_way;

  // downward scans so the lowest index wins
  always_comb begin
    inv_any  = 1'b0;
    free_any = 1'b0;
    inv_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(w);
      end
      if (vld_i[w] && !prot_i[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    found_o = inv_any | free_any;
    way_o   = inv_any ? inv_way : free_way;
  end
endmodule

// File: rtl/pd_repl_unit.sv
module pd_repl_unit #(
  parameter int WAYS    = 8,
  parameter int THREADS = 4,
  parameter int CNT_W   = 8,
  parameter int DEF_PD  = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TID_W  = $clog2(THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_hit_i,
  input  logic [WAY_W-1:0] acc_way_i,
  input  logic [TID_W-1:0] acc_tid_i,
  input  logic             pd_we_i,
  input  logic [TID_W-1:0] pd_idx_i,
  input  logic [CNT_W-1:0] pd_data_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic             bypass_o,
  output logic             fill_ok_o
);
  import pd_pkg::*;

  logic [CNT_W-1:0]           cur_pd;
  logic [WAYS-1:0][CNT_W-1:0] cnt;
  logic [WAYS-1:0]            vld, prot, ld, set_vld;
  logic                       found;
  logic [WAY_W-1:0]           pick;
  logic                       miss, do_fill;
  miss_out_e                  out_q;
  logic [WAY_W-1:0]           way_q;

  pd_table #(.THREADS(THREADS), .CNT_W(CNT_W), .DEF_PD(DEF_PD)) i_tbl (
    .clk_i, .rst_ni,
    .we_i(pd_we_i), .wr_idx_i(pd_idx_i), .wr_data_i(pd_data_i),
    .rd_idx_i(acc_tid_i), .rd_pd_o(cur_pd)
  );

  way_ctr #(.WAYS(WAYS), .CNT_W(CNT_W)) i_ctr (
    .clk_i, .rst_ni,
    .acc_i(acc_valid_i), .ld_i(ld), .set_vld_i(set_vld), .ld_val_i(cur_pd),
    .cnt_o(cnt), .vld_o(vld)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_prot
    assign prot[w] = cnt[w] != '0;
  end

  victim_pick #(.WAYS(WAYS)) i_pick (
    .vld_i(vld), .prot_i(prot), .found_o(found), .way_o(pick)
  );

  assign miss    = acc_valid_i && !acc_hit_i;
  assign do_fill = miss && found;

  always_comb begin
    ld      = '0;
    set_vld = '0;
    if (acc_valid_i && acc_hit_i) ld[acc_way_i] = 1'b1;
    if (do_fill) begin
      ld[pick]      = 1'b1;
      set_vld[pick] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= OUT_NONE;
      way_q <= '0;
    end else begin
      out_q <= !miss ? OUT_NONE : (found ? OUT_FILL : OUT_BYP);
      way_q <= do_fill ? pick : '0;
    end
  end

  assign bypass_o     = out_q == OUT_BYP;
  assign fill_ok_o    = out_q == OUT_FILL;
  assign victim_way_o = way_q;

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bypass_o && fill_ok_o));
  // R10
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss |=> !bypass_o && !fill_ok_o && victim_way_o == '0);
  // R3
  victim_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_fill |-> (!vld[pick] || cnt[pick] == '0));
  // R6
  bypass_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss && !found) |-> (&vld && &prot));
  // R3
  fill_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_fill |=> vld[$past(pick)] && cnt[$past(pick)] == $past(cur_pd));
endmodule

// File: tb/test_pd_repl_unit.sv
`timescale 1ns/1ps
module test_pd_repl_unit;
  localparam int WAYS = 4, THREADS = 4, CNT_W = 4, DEF_PD = 3;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       acc_valid_i = 0, acc_hit_i = 0, pd_we_i = 0;
  logic [1:0] acc_way_i = 0, acc_tid_i = 0, pd_idx_i = 0;
  logic [3:0] pd_data_i = 0;
  logic [1:0] victim_way_o;
  logic       bypass_o, fill_ok_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_cnt[WAYS], m_pd[THREADS];
  bit m_val[WAYS];

  always #2.5 clk_i = ~clk_i;

  pd_repl_unit #(.WAYS(WAYS), .THREADS(THREADS), .CNT_W(CNT_W), .DEF_PD(DEF_PD)) i_pd_repl_unit (
    .clk_i, .rst_ni, .acc_valid_i, .acc_hit_i, .acc_way_i, .acc_tid_i,
    .pd_we_i, .pd_idx_i, .pd_data_i, .victim_way_o, .bypass_o, .fill_ok_o
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int w = 0; w < WAYS; w++) begin m_cnt[w] = 0; m_val[w] = 0; end
    for (int t = 0; t < THREADS; t++) m_pd[t] = DEF_PD;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic pd_wr(input int idx, input int data);
    pd_we_i = 1; pd_idx_i = 2'(idx); pd_data_i = 4'(data);
    @(negedge clk_i);
    pd_we_i = 0;
    m_pd[idx] = data;
  endtask

  // tag "" selects the requirement from the expected outcome
  task automatic acc(input bit hit, input int way, input int tid, input string tag);
    int v = -1; bit byp = 0, fill, inv = 0; string t;
    if (!hit) begin
      for (int w = WAYS - 1; w >= 0; w--) if (!m_val[w]) begin v = w; inv = 1; end
      if (v < 0) for (int w = WAYS - 1; w >= 0; w--) if (m_val[w] && m_cnt[w] == 0) v = w;
      byp = v < 0;
    end
    fill = !hit && !byp;
    acc_valid_i = 1; acc_hit_i = hit; acc_way_i = 2'(way); acc_tid_i = 2'(tid);
    @(negedge clk_i);
    acc_valid_i = 0;
    t = tag;
    if (t == "") t = hit ? "R10" : byp ? "R6" : inv ? "R4" : "R5";
    chk(t, int'(fill_ok_o), int'(fill), "fill_ok");
    chk(t, int'(bypass_o), int'(byp), "bypass");
    chk(t, int'(victim_way_o), fill ? v : 0, "victim");
    for (int w = 0; w < WAYS; w++) begin
      if ((hit && w == way) || (fill && w == v)) begin
        m_cnt[w] = m_pd[tid];
        if (fill) m_val[w] = 1;
      end else if (m_cnt[w] > 0) m_cnt[w]--;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int lf;
    do_reset();
    // R1
    chk("R1", int'(bypass_o), 0, "bypass after reset");
    chk("R1", int'(fill_ok_o), 0, "fill_ok after reset");
    chk("R1", int'(victim_way_o), 0, "victim after reset");
    // R1 R4: invalid ways fill lowest first with default length
    for (int i = 0; i < 4; i++) acc(0, 0, 2, "R4");
    acc(0, 0, 2, "R1");          // way0 aged to 0 with DEF_PD=3
    acc(1, 1, 0, "R10");
    acc(0, 0, 0, "R5");

    // R6 R7: fully protected set bypasses until way0 drains
    do_reset();
    pd_wr(0, 15);
    for (int i = 0; i < 4; i++) acc(0, 0, 0, "R3");
    for (int i = 0; i < 12; i++) acc(0, 0, 0, "R6");
    acc(0, 0, 0, "R7");

    // R2: a hit reloads way0 so way1 drains first
    do_reset();
    pd_wr(0, 15);
    for (int i = 0; i < 4; i++) acc(0, 0, 0, "R3");
    acc(1, 0, 0, "R2");
    for (int i = 0; i < 12; i++) acc(0, 0, 0, "R2");

    // R8 R9: thread 1 uses its own rewritten length
    do_reset();
    pd_wr(0, 15);
    pd_wr(1, 0);
    acc(0, 0, 0, "R9");
    acc(0, 0, 1, "R8");
    acc(0, 0, 0, "R9");
    acc(0, 0, 0, "R9");
    acc(0, 0, 0, "R9");          // way1 unprotected
    acc(0, 0, 0, "R6");

    // mixed sweep
    do_reset();
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]} & 16'hFFFF;
      if (lf[4:0] == 5'd7) pd_wr(lf[7:6], lf[11:8]);
      else if (lf[5:0] == 6'd9) @(negedge clk_i);
      else acc(lf[1] && m_val[lf[3:2]], lf[3:2], lf[9:8], "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule